// File: doc/BRIEF.md
# Packed 4:2:2 to BGR Stream Converter

This block turns a stream of packed YUV 4:2:2 camera words into 24-bit BGR pixels. Each 32-bit input word carries two horizontally adjacent pixels. The two pixels have their own luma samples and share one pair of chroma samples. The block converts each pixel with fixed-point BT.601 limited-range arithmetic, rounds the result and saturates it to 8 bits per channel. It sits as one stage of a buffer-less streaming pipeline, between a reader and a resizer. It emits an interleaved BGR stream and also splits the same pixels into three single-channel planar streams, one each for blue, green and red, so that per-channel work downstream can run in parallel.

Frame width and height are runtime inputs. The block counts words itself. It marks the first pixel of every frame with a start-of-frame flag and the last pixel of every row with an end-of-line flag. Every stream uses valid/ready. A sink holds its beat while its ready is low. A pixel leaves the output register only after every enabled sink has taken it, each at its own pace. While that pixel waits, input ready falls and no word is dropped. Each accepted word occupies two output cycles, so input ready is always low in the cycle right after a word is accepted.

Top module: `yuv422_bgr_conv`

## Requirements
- R1: During and right after reset, out_valid and all pl_valid bits are 0 and in_ready is 1.
- R2: Input word layout is bits [7:0] = U, [15:8] = Y0, [23:16] = V, [31:24] = Y1. The Y0 pixel is emitted before the Y1 pixel, and both use the same U and V.
- R3: With C = Y-16, D = U-128 and E = V-128, the outputs are R = (298C + 409E + 128) >> 8, G = (298C - 100D - 208E + 128) >> 8 and B = (298C + 516D + 128) >> 8, where >> is an arithmetic (floor) shift.
- R4: Each channel result below 0 becomes 0, and each result above 255 becomes 255.
- R5: out_bgr carries B in bits [23:16], G in [15:8] and R in [7:0].
- R6: in_ready is 0 in the cycle after an input handshake. With all sinks ready, back-to-back words are accepted every 2 cycles.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bgr, out_sof and out_eol hold. No pixel is lost or duplicated.
- R8: Planar stream 0 carries B, stream 1 carries G and stream 2 carries R, in pl_data[8i+7:8i]. Each has its own valid/ready and holds its beat while stalled. The next pixel is presented only after all four sinks have taken the current one.
- R9: out_sof is 1 only on the first pixel of a frame, meaning the first pixel after reset or after the last row of the previous frame.
- R10: out_eol is 1 on the second pixel of the last word of each row. A row holds frame_w/2 words, and the low bit of frame_w is ignored.
- R11: After frame_h rows the row count wraps, and the next pixel again carries out_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_w | input | 16 | Frame width in pixels (low bit ignored) |
| frame_h | input | 16 | Frame height in rows |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Converter can take a word |
| in_data | input | 32 | Packed word U, Y0, V, Y1 from low byte up |
| out_valid | output | 1 | Interleaved pixel valid |
| out_ready | input | 1 | Interleaved sink ready |
| out_bgr | output | 24 | Pixel, B in the high byte |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of row |
| pl_valid | output | 3 | Planar valid, index 0 B, 1 G, 2 R |
| pl_ready | input | 3 | Planar sink ready |
| pl_data | output | 24 | Planar bytes, plane i in bits [8i+7:8i] |

## Verification
The Y0 pixel of a word is registered at the clock edge after the word's handshake. The Y1 pixel follows at the first edge after every sink has taken the Y0 pixel, and in_ready is low in the cycle straight after the handshake. The bench predicts both pixels and all three planar bytes when it sees the handshake and queues them. A monitor compares each queued item at the beat where the matching valid and ready are both high, so varying back-pressure never moves the point of comparison. The bench also checks the two-cycle word spacing and the low in_ready right after each handshake, both with all sinks held ready.

// File: rtl/yb_pkg.sv
package yb_pkg;
  typedef struct packed {
    logic [7:0] b;
    logic [7:0] g;
    logic [7:0] r;
  } bgr_t;

  localparam int FRAC   = 8;
  localparam int K_Y    = 298;
  localparam int K_RV   = 409;
  localparam int K_GU   = 100;
  localparam int K_GV   = 208;
  localparam int K_BU   = 516;
  localparam int HALF   = 1 << (FRAC - 1);
  localparam int ACC_W  = 20;

  function automatic logic [7:0] sat8(input logic signed [ACC_W-1:0] v);
    if (v < 0)        return 8'd0;
    else if (v > 255) return 8'd255;
    else              return v[7:0];
  endfunction
endpackage

// File: rtl/yb_word_unpack.sv
module yb_word_unpack #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             take,
  output logic             pix_valid,
  output logic [7:0]       pix_y,
  output logic [7:0]       pix_u,
  output logic [7:0]       pix_v,
  output logic             pix_sof,
  output logic             pix_eol
);
  logic [31:0]      word_q;
  logic             full_q, phase_q, sof_q, eol_q;
  logic [DIM_W-1:0] col_q, row_q;
  logic [DIM_W-1:0] wpl;
  logic             last_col, accept;

  assign wpl      = frame_w >> 1;
  assign last_col = (col_q == wpl - 1'b1);
  assign in_ready = !full_q || (phase_q && take);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      phase_q <= 1'b0;
      word_q  <= '0;
      sof_q   <= 1'b0;
      eol_q   <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
    end else if (accept) begin
      word_q  <= in_data;
      full_q  <= 1'b1;
      phase_q <= 1'b0;
      sof_q   <= (col_q == '0) && (row_q == '0);
      eol_q   <= last_col;
      if (last_col) begin
        col_q <= '0;
        row_q <= (row_q == frame_h - 1'b1) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else if (full_q && take) begin
      phase_q <= ~phase_q;
      if (phase_q) full_q <= 1'b0;
    end
  end

  assign pix_valid = full_q;
  assign pix_u     = word_q[7:0];
  assign pix_v     = word_q[23:16];
  assign pix_y     = phase_q ? word_q[31:24] : word_q[15:8];
  assign pix_sof   = sof_q && !phase_q;
  assign pix_eol   = eol_q && phase_q;

  // R6
  rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wpl != '0) |-> (col_q < wpl));
endmodule

// File: rtl/yb_csc.sv
module yb_csc
  import yb_pkg::*;
(
  input  logic [7:0] y,
  input  logic [7:0] u,
  input  logic [7:0] v,
  output bgr_t       pix
);
  logic signed [ACC_W-1:0] c, d, e;
  logic signed [ACC_W-1:0] acc_r, acc_g, acc_b;

  always_comb begin
    c = ACC_W'(signed'({1'b0, y})) - ACC_W'(16);
    d = ACC_W'(signed'({1'b0, u})) - ACC_W'(128);
    e = ACC_W'(signed'({1'b0, v})) - ACC_W'(128);
    acc_r = (ACC_W'(K_Y) * c + ACC_W'(K_RV) * e + ACC_W'(HALF)) >>> FRAC;
    acc_g = (ACC_W'(K_Y) * c - ACC_W'(K_GU) * d - ACC_W'(K_GV) * e
             + ACC_W'(HALF)) >>> FRAC;
    acc_b = (ACC_W'(K_Y) * c + ACC_W'(K_BU) * d + ACC_W'(HALF)) >>> FRAC;
    pix.r = sat8(acc_r);
    pix.g = sat8(acc_g);
    pix.b = sat8(acc_b);
  end
endmodule

// File: rtl/yb_out_fork.sv
module yb_out_fork
  import yb_pkg::*;
#(
  parameter bit PLANAR_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_valid,
  input  bgr_t        src_pix,
  input  logic        src_sof,
  input  logic        src_eol,
  output logic        src_take,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_bgr,
  output logic        out_sof,
  output logic        out_eol,
  output logic [2:0]  pl_valid,
  input  logic [2:0]  pl_ready,
  output logic [23:0] pl_data
);
  localparam int NS = 4;
  localparam logic [NS-1:0] TAKEN_INIT = PLANAR_EN ? '0 : 4'b1110;

  bgr_t          pix_q;
  logic          full_q, sof_q, eol_q;
  logic [NS-1:0] taken_q, sink_valid, sink_ready, done;
  logic          all_done;

  assign sink_ready = {pl_ready, out_ready};
  assign sink_valid = {NS{full_q}} & ~taken_q;
  assign done       = taken_q | (sink_valid & sink_ready);
  assign all_done   = &done;
  assign src_take   = !full_q || all_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      taken_q <= TAKEN_INIT;
      pix_q   <= '0;
      sof_q   <= 1'b0;
      eol_q   <= 1'b0;
    end else if (src_take) begin
      full_q  <= src_valid;
      taken_q <= TAKEN_INIT;
      if (src_valid) begin
        pix_q <= src_pix;
        sof_q <= src_sof;
        eol_q <= src_eol;
      end
    end else begin
      taken_q <= done;
    end
  end

  assign out_valid = sink_valid[0];
  assign out_bgr   = pix_q;
  assign out_sof   = sof_q;
  assign out_eol   = eol_q;

  generate
    if (PLANAR_EN) begin : g_planar
      assign pl_valid = sink_valid[3:1];
      assign pl_data  = {pix_q.r, pix_q.g, pix_q.b};
    end else begin : g_no_planar
      assign pl_valid = 3'b000;
      assign pl_data  = '0;
    end
  endgenerate

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bgr)
                                   && $stable(out_sof) && $stable(out_eol)));

  for (genvar i = 0; i < 3; i++) begin : g_pl_chk
    // R8
    pl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_valid[i] && !pl_ready[i]) |=> (pl_valid[i] && $stable(pl_data[8*i +: 8])));
  end
endmodule

// File: rtl/yuv422_bgr_conv.sv
module yuv422_bgr_conv
  import yb_pkg::*;
#(
  parameter int DIM_W     = 16,
  parameter bit PLANAR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [23:0]      out_bgr,
  output logic             out_sof,
  output logic             out_eol,
  output logic [2:0]       pl_valid,
  input  logic [2:0]       pl_ready,
  output logic [23:0]      pl_data
);
  logic       pix_valid, pix_sof, pix_eol, take;
  logic [7:0] pix_y, pix_u, pix_v;
  bgr_t       conv;

  yb_word_unpack #(.DIM_W(DIM_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .take(take), .pix_valid(pix_valid), .pix_y(pix_y), .pix_u(pix_u),
    .pix_v(pix_v), .pix_sof(pix_sof), .pix_eol(pix_eol)
  );

  yb_csc u_csc (.y(pix_y), .u(pix_u), .v(pix_v), .pix(conv));

  yb_out_fork #(.PLANAR_EN(PLANAR_EN)) u_fork (
    .clk(clk), .rst_n(rst_n), .src_valid(pix_valid), .src_pix(conv),
    .src_sof(pix_sof), .src_eol(pix_eol), .src_take(take),
    .out_valid(out_valid), .out_ready(out_ready), .out_bgr(out_bgr),
    .out_sof(out_sof), .out_eol(out_eol), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .pl_data(pl_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && pl_valid == 3'b000 && in_ready));
endmodule

// File: tb/tb_yuv422_bgr_conv.sv
module tb_yuv422_bgr_conv;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] frame_w, frame_h;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid, out_ready, out_sof, out_eol;
  logic [23:0] out_bgr;
  logic [2:0]  pl_valid, pl_ready;
  logic [23:0] pl_data;

  always #10 clk = ~clk;

  yuv422_bgr_conv dut (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_bgr(out_bgr),
    .out_sof(out_sof), .out_eol(out_eol), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .pl_data(pl_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [25:0] exp_q[$];
  logic [7:0]  pq0[$], pq1[$], pq2[$];
  bit    rand_rdy = 0;
  string cur_tag = "R3";
  int    tb_col = 0, tb_row = 0, last_acc = -1;
  bit    hold_pend = 0;
  logic [25:0] hold_val;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] sat(input int x);
    if (x < 0) return 8'd0;
    if (x > 255) return 8'd255;
    return x[7:0];
  endfunction

  function automatic logic [23:0] ref_bgr(input int y, input int u, input int v);
    int c, d, e;
    c = y - 16; d = u - 128; e = v - 128;
    return {sat((298*c + 516*d + 128) >>> 8),
            sat((298*c - 100*d - 208*e + 128) >>> 8),
            sat((298*c + 409*e + 128) >>> 8)};
  endfunction

  task automatic push_pix(input logic [23:0] p, input bit s, input bit e);
    exp_q.push_back({s, e, p});
    pq0.push_back(p[23:16]);
    pq1.push_back(p[15:8]);
    pq2.push_back(p[7:0]);
  endtask

  task automatic send_word(input logic [7:0] u, input logic [7:0] y0,
                           input logic [7:0] v, input logic [7:0] y1,
                           input bit gap_chk);
    int wpl;
    bit s, e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {y1, v, y0, u};
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    wpl = int'(frame_w >> 1);
    s = (tb_col == 0) && (tb_row == 0);
    e = (tb_col == wpl - 1);
    push_pix(ref_bgr(y0, u, v), s, 1'b0);
    push_pix(ref_bgr(y1, u, v), 1'b0, e);
    if (e) begin
      tb_col = 0;
      tb_row = (tb_row == int'(frame_h) - 1) ? 0 : tb_row + 1;
    end else tb_col++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 ready after accept", {31'd0, in_ready}, 32'd0);
    if (gap_chk && last_acc >= 0)
      chk(cyc - last_acc == 2, "R6 word spacing", cyc - last_acc, 32'd2);
    last_acc = cyc;
  endtask

  // Monitor: sets readies at the falling edge, compares beats before the rising edge
  initial begin
    out_ready = 1'b1;
    pl_ready  = 3'b111;
    forever begin
      @(negedge clk);
      out_ready = rand_rdy ? 1'($urandom % 2) : 1'b1;
      pl_ready  = rand_rdy ? 3'($urandom % 8) : 3'b111;
      #2;
      if (rst_n) begin
        if (hold_pend) begin
          chk(out_valid && {out_sof, out_eol, out_bgr} == hold_val, "R7 hold",
              {5'd0, out_valid, out_sof, out_eol, out_bgr}, {6'd1, hold_val});
          hold_pend = 0;
        end
        if (out_valid && !out_ready) begin
          hold_pend = 1;
          hold_val  = {out_sof, out_eol, out_bgr};
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R7 extra pixel", {8'd0, out_bgr}, 32'd0);
          else begin
            logic [25:0] x;
            x = exp_q.pop_front();
            chk(out_bgr == x[23:0], {cur_tag, "/R5 pixel"}, {8'd0, out_bgr}, {8'd0, x[23:0]});
            chk(out_sof == x[25], "R9/R11 sof", {31'd0, out_sof}, {31'd0, x[25]});
            chk(out_eol == x[24], "R10 eol", {31'd0, out_eol}, {31'd0, x[24]});
          end
        end
        if (pl_valid[0] && pl_ready[0]) begin
          if (pq0.size() == 0) chk(1'b0, "R8 extra B", {24'd0, pl_data[7:0]}, 32'd0);
          else begin
            logic [7:0] b;
            b = pq0.pop_front();
            chk(pl_data[7:0] == b, "R8 plane B", {24'd0, pl_data[7:0]}, {24'd0, b});
          end
        end
        if (pl_valid[1] && pl_ready[1]) begin
          if (pq1.size() == 0) chk(1'b0, "R8 extra G", {24'd0, pl_data[15:8]}, 32'd0);
          else begin
            logic [7:0] g;
            g = pq1.pop_front();
            chk(pl_data[15:8] == g, "R8 plane G", {24'd0, pl_data[15:8]}, {24'd0, g});
          end
        end
        if (pl_valid[2] && pl_ready[2]) begin
          if (pq2.size() == 0) chk(1'b0, "R8 extra R", {24'd0, pl_data[23:16]}, 32'd0);
          else begin
            logic [7:0] r;
            r = pq2.pop_front();
            chk(pl_data[23:16] == r, "R8 plane R", {24'd0, pl_data[23:16]}, {24'd0, r});
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    frame_w = 16'd6; frame_h = 16'd2;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && pl_valid == 3'b000 && in_ready, "R1 reset state",
        {27'd0, out_valid, pl_valid, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // Pair order and shared chroma, one full frame 6x2, all sinks ready
    cur_tag = "R2"; last_acc = -1;
    for (int i = 0; i < 6; i++)
      send_word(8'(60 + 20*i), 8'(40 + 30*i), 8'(200 - 25*i), 8'(180 - 20*i), 1'b1);

    // Saturation cases, second frame (sof again after wrap, R11)
    cur_tag = "R4"; last_acc = -1;
    send_word(8'd128, 8'd255, 8'd255, 8'd0,   1'b1);
    send_word(8'd0,   8'd0,   8'd0,   8'd255, 1'b1);
    send_word(8'd255, 8'd235, 8'd0,   8'd16,  1'b1);
    send_word(8'd255, 8'd255, 8'd255, 8'd255, 1'b1);
    send_word(8'd0,   8'd16,  8'd255, 8'd0,   1'b1);
    send_word(8'd128, 8'd128, 8'd128, 8'd128, 1'b1);

    // Odd width 7 treated as 6, height 3, random data and back-pressure
    cur_tag = "R3"; rand_rdy = 1;
    frame_w = 16'd7; frame_h = 16'd3;
    for (int i = 0; i < 18; i++)
      send_word(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);

    for (int t = 0; t < 400 && (exp_q.size() + pq0.size() + pq1.size() + pq2.size()) != 0; t++)
      @(negedge clk);
    rand_rdy = 0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all pixels delivered", exp_q.size(), 32'd0);
    chk(pq0.size() + pq1.size() + pq2.size() == 0, "R8 all planes delivered",
        pq0.size() + pq1.size() + pq2.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule